// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, latches their rising edges, and picks the most urgent unmasked request against what is already being serviced. When a request wins, the interrupt output goes high. A one-cycle acknowledge strobe then returns an 8-bit vector, which is the programmed base plus the input number. In normal mode the winning input is also marked as in service. Software later releases it with a specific end-of-interrupt command. In automatic mode no in-service mark is kept at all.

Software reaches the block through a byte-wide bus. A select bit picks between the command port and the data port. Writing the initialisation opcode to the command port takes the controller offline. The next three data-port writes then load, in this order, the vector base, the cascade word and the mode word. The controller goes live after the third of these writes.

After that, data-port writes and reads go to the mask register. Command-port reads return either the request register or the in-service register, whichever was last selected by a command. A request that disappears before its acknowledge is still answered, with the vector of input 7 and no change to the in-service register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request register reads 0x00, the mask reads 0xFF and command-port reads return the request register. `int_out` stays low until the initialisation sequence has completed, even while inputs are pending.
- R2: A command-port write of 0x11 starts initialisation. It forces the mask to 0xFF and clears the in-service register. The next three data-port writes are taken, in order, as vector base, cascade word and mode word. The mask still reads 0xFF once the sequence ends.
- R3: Mode word bit 1 set selects automatic end of interrupt. Mode word bit 2 set selects master, clear selects slave. As master, `slave_map` shows the cascade word and `slave_id` is 0. As slave, `slave_map` is 0 and `slave_id` shows cascade word bits 2:0.
- R4: While the controller is live, a data-port write loads the mask and a data-port read returns exactly the value written.
- R5: A rising edge on input n sets request bit n. The bit clears when input n goes low, or when that input is acknowledged, even if the input stays high.
- R6: Input 0 has the highest priority and input 7 the lowest. `int_out` is high when some unmasked request bit is set and no in-service bit at the same or a higher priority is set.
- R7: An acknowledge strobe, given while a request is granted, sets `vec_valid` for one cycle on the next clock with `vec_out` equal to base plus n. In normal mode it also sets in-service bit n and clears request bit n.
- R8: In automatic mode an acknowledge leaves the in-service register unchanged, and further requests are granted without any end-of-interrupt command.
- R9: Command 0x60+n (n = 0..7) clears in-service bit n and leaves the other bits unchanged.
- R10: Command 0x0B makes later command-port reads return the in-service register. Command 0x0A makes them return the request register.
- R11: An acknowledge with no granted request returns base plus 7 and leaves the in-service register unchanged. This happens even when input 7 is masked.
- R12: Command values other than 0x11, 0x0A, 0x0B and 0x60..0x67 change no register: the mask, the in-service register and the live state all stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the command port, 1 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to the processor |
| int_ack | input | 1 | Acknowledge strobe |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | One-cycle flag, vec_out is fresh |
| slave_map | output | 8 | Inputs with a slave attached (master mode) |
| slave_id | output | 3 | Own identity number (slave mode) |

## Verification
Corruption of the in-service register shows up at the ports within one cycle. It appears as a missing or extra `int_out` for requests of lower priority than the corrupted bit, and on the next in-service read-back. A wrong request-register bit changes the vector of the next acknowledge, or turns a real vector into the spurious one. A sequencer that counts initialisation writes wrongly shows up as a mask read-back that does not match, or as a wrong vector base on the first acknowledge. Every acknowledge vector is therefore compared in issue order, and the register read-backs are taken right after each command.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NIN   = 8;
    localparam int IDX_W = $clog2(NIN);
    localparam int BUS_W = 8;

    localparam logic [BUS_W-1:0] CMD_INIT    = 8'h11;
    localparam logic [BUS_W-1:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [BUS_W-1:0] CMD_SEL_ISR = 8'h0B;
    localparam logic [BUS_W-IDX_W-1:0] CMD_EOI_TAG = 5'b01100;

    localparam int MODE_AEOI_BIT   = 1;
    localparam int MODE_MASTER_BIT = 2;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_BASE,
        PH_CASC,
        PH_MODE,
        PH_RUN
    } phase_t;

    typedef struct packed {
        phase_t           phase;
        logic [BUS_W-1:0] vbase;
        logic [BUS_W-1:0] casc;
        logic             aeoi;
        logic             master;
        logic [NIN-1:0]   mask;
        logic [NIN-1:0]   isr;
        logic             sel_isr;
        logic [BUS_W-1:0] vec;
        logic             vec_vld;
    } ctl_t;
endpackage

// File: rtl/pic_req.sv
module pic_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] irr;
    } req_t;

    req_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = irq_in;
        for (int i = 0; i < N; i++) begin
            r_d.irr[i] = ((r_q.irr[i] & ~clr[i]) | (irq_in[i] & ~r_q.prev[i])) & irq_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irr = r_q.irr;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     irr,
    input  logic [N-1:0]     mask,
    input  logic [N-1:0]     isr,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [N-1:0] pend;
    logic [N-1:0] upto;
    logic         found;
    logic         blocked;

    assign pend = irr & ~mask;

    always_comb begin
        found   = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && pend[i]) begin
                found   = 1'b1;
                gnt_idx = IDX_W'(i);
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_upto
            assign upto[g] = (IDX_W'(g) <= gnt_idx);
        end
    endgenerate

    assign blocked = |(isr & upto);
    assign gnt_vld = found & ~blocked;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic                  dat_wr,
    input  logic [BUS_W-1:0]      wdata,
    input  logic                  ack,
    input  logic                  gnt_vld,
    input  logic [IDX_W-1:0]      gnt_idx,
    output ctl_t                  st,
    output logic [NIN-1:0]        irr_clr
);
    ctl_t s_d, s_q;
    logic run;

    assign run = (s_q.phase == PH_RUN);

    always_comb begin
        s_d         = s_q;
        s_d.vec_vld = 1'b0;
        irr_clr     = '0;

        if (cmd_wr) begin
            if (wdata == CMD_INIT) begin
                s_d.phase   = PH_BASE;
                s_d.mask    = '1;
                s_d.isr     = '0;
                s_d.sel_isr = 1'b0;
            end else if (run) begin
                if (wdata[BUS_W-1:IDX_W] == CMD_EOI_TAG) begin
                    s_d.isr[wdata[IDX_W-1:0]] = 1'b0;
                end else if (wdata == CMD_SEL_IRR) begin
                    s_d.sel_isr = 1'b0;
                end else if (wdata == CMD_SEL_ISR) begin
                    s_d.sel_isr = 1'b1;
                end
            end
        end

        if (dat_wr) begin
            case (s_q.phase)
                PH_BASE: begin
                    s_d.vbase = wdata;
                    s_d.phase = PH_CASC;
                end
                PH_CASC: begin
                    s_d.casc  = wdata;
                    s_d.phase = PH_MODE;
                end
                PH_MODE: begin
                    s_d.aeoi   = wdata[MODE_AEOI_BIT];
                    s_d.master = wdata[MODE_MASTER_BIT];
                    s_d.phase  = PH_RUN;
                end
                PH_RUN:  s_d.mask = wdata;
                default: ;
            endcase
        end

        if (ack && run) begin
            s_d.vec_vld = 1'b1;
            if (gnt_vld) begin
                s_d.vec          = s_q.vbase + BUS_W'(gnt_idx);
                irr_clr[gnt_idx] = 1'b1;
                if (!s_q.aeoi) s_d.isr[gnt_idx] = 1'b1;
            end else begin
                s_d.vec = s_q.vbase + BUS_W'(NIN - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_OFF;
            s_q.mask  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign st = s_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NIN-1:0]   irq_in,
    output logic             int_out,
    input  logic             int_ack,
    output logic [BUS_W-1:0] vec_out,
    output logic             vec_valid,
    output logic [BUS_W-1:0] slave_map,
    output logic [2:0]       slave_id
);
    ctl_t             st;
    logic             cmd_wr;
    logic             dat_wr;
    logic [NIN-1:0]   irr_q;
    logic [NIN-1:0]   irr_clr;
    logic [NIN-1:0]   mask_q;
    logic [NIN-1:0]   isr_q;
    logic             gnt_vld;
    logic [IDX_W-1:0] gnt_idx;
    logic             active;
    logic             init_busy;
    logic             aeoi;

    assign cmd_wr = bus_wr & ~bus_sel;
    assign dat_wr = bus_wr &  bus_sel;

    pic_req #(.N(NIN)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .clr    (irr_clr),
        .irr    (irr_q)
    );

    pic_resolver #(.N(NIN), .IDX_W(IDX_W)) u_res (
        .irr     (irr_q),
        .mask    (mask_q),
        .isr     (isr_q),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    pic_ctrl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .dat_wr  (dat_wr),
        .wdata   (bus_wdata),
        .ack     (int_ack),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx),
        .st      (st),
        .irr_clr (irr_clr)
    );

    assign mask_q    = st.mask;
    assign isr_q     = st.isr;
    assign aeoi      = st.aeoi;
    assign active    = (st.phase == PH_RUN);
    assign init_busy = (st.phase == PH_BASE) || (st.phase == PH_CASC) || (st.phase == PH_MODE);

    assign int_out   = active & gnt_vld;
    assign vec_out   = st.vec;
    assign vec_valid = st.vec_vld;
    assign bus_rdata = bus_sel    ? st.mask :
                       st.sel_isr ? st.isr  : irr_q;
    assign slave_map = st.master ? st.casc : '0;
    assign slave_id  = st.master ? 3'd0    : st.casc[2:0];
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             init_busy,
    input logic             int_out,
    input logic             int_ack,
    input logic             vec_valid,
    input logic             cmd_wr,
    input logic [BUS_W-1:0] wdata,
    input logic [NIN-1:0]   mask,
    input logic [NIN-1:0]   isr,
    input logic [NIN-1:0]   irr,
    input logic [NIN-1:0]   irq_in,
    input logic             aeoi
);
    AST_INT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !int_out); // R1

    AST_INIT_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> (mask == '1)); // R2

    AST_IRR_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~$past(irq_in)) == '0)); // R5

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack && active)); // R7

    AST_AEOI_NO_ISR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (active && aeoi && int_ack) |=> ((isr & ~$past(isr)) == '0)); // R8

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd_wr && !int_ack && wdata[BUS_W-1:IDX_W] == CMD_EOI_TAG)
        |=> !isr[$past(wdata[IDX_W-1:0])]); // R9
endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .init_busy (init_busy),
    .int_out   (int_out),
    .int_ack   (int_ack),
    .vec_valid (vec_valid),
    .cmd_wr    (cmd_wr),
    .wdata     (bus_wdata),
    .mask      (mask_q),
    .isr       (isr_q),
    .irr       (irr_q),
    .irq_in    (irq_in),
    .aeoi      (aeoi)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [7:0] slave_map;
    logic [2:0] slave_id;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out),
        .vec_valid(vec_valid), .slave_map(slave_map), .slave_id(slave_id)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic sel, output logic [7:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack(input logic [7:0] exp);
        exp_q.push_back(exp);
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    // monitor: vectors compared in issue order (R7, R11)
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 unexpected vector actual=%02h expected=none", vec_out);
            end else begin
                check8("R7 vector", vec_out, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check8("R1 int_out", {7'd0, int_out}, 8'h00);
        bread(1'b0, v); check8("R1 irr", v, 8'h00);
        bread(1'b1, v); check8("R1 mask", v, 8'hFF);
        set_irq(8'h08);
        check8("R1 inactive int_out", {7'd0, int_out}, 8'h00);

        // R2 init sequence, master, normal EOI
        bwrite(1'b0, 8'h11);
        bread(1'b1, v); check8("R2 mask during init", v, 8'hFF);
        bwrite(1'b1, 8'h20);
        bwrite(1'b1, 8'h04);
        bwrite(1'b1, 8'h04);
        check8("R3 master map", slave_map, 8'h04);
        check8("R3 master id", {5'd0, slave_id}, 8'h00);
        bread(1'b1, v); check8("R2 mask after init", v, 8'hFF);
        check8("R6 all masked", {7'd0, int_out}, 8'h00);
        bread(1'b0, v); check8("R5 edge latched", v, 8'h08);

        // R4 mask readback
        bwrite(1'b1, 8'hA5);
        bread(1'b1, v); check8("R4 mask A5", v, 8'hA5);
        bwrite(1'b1, 8'h00);
        bread(1'b1, v); check8("R4 mask 00", v, 8'h00);

        // R7 acknowledge
        check8("R6 int_out irq3", {7'd0, int_out}, 8'h01);
        do_ack(8'h23);
        bwrite(1'b0, 8'h0B);
        bread(1'b0, v); check8("R10 isr after ack", v, 8'h08);
        bwrite(1'b0, 8'h0A);
        bread(1'b0, v); check8("R5 irr cleared by ack", v, 8'h00);

        // R6 priority against in-service
        set_irq(8'h28);
        check8("R6 lower blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h2A);
        check8("R6 higher granted", {7'd0, int_out}, 8'h01);
        do_ack(8'h21);
        bwrite(1'b0, 8'h0B);
        bread(1'b0, v); check8("R7 isr two bits", v, 8'h0A);

        // R9 specific EOI
        bwrite(1'b0, 8'h61);
        bread(1'b0, v); check8("R9 eoi 1", v, 8'h08);
        check8("R6 still blocked", {7'd0, int_out}, 8'h00);

        // R12 unrecognised commands
        bwrite(1'b0, 8'h68);
        bread(1'b0, v); check8("R12 0x68 isr", v, 8'h08);
        bwrite(1'b0, 8'h13);
        bread(1'b0, v); check8("R12 0x13 isr", v, 8'h08);
        bread(1'b1, v); check8("R12 0x13 mask", v, 8'h00);

        bwrite(1'b0, 8'h63);
        bread(1'b0, v); check8("R9 eoi 3", v, 8'h00);
        check8("R6 irq5 now granted", {7'd0, int_out}, 8'h01);
        do_ack(8'h25);
        bwrite(1'b0, 8'h65);
        bread(1'b0, v); check8("R9 eoi 5", v, 8'h00);

        // R6 mask and R11 spurious
        set_irq(8'h00);
        bwrite(1'b1, 8'h84);
        set_irq(8'h04);
        check8("R6 masked input", {7'd0, int_out}, 8'h00);
        bwrite(1'b1, 8'h80);
        check8("R6 unmasked input", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        check8("R5 drop clears", {7'd0, int_out}, 8'h00);
        do_ack(8'h27);
        bread(1'b0, v); check8("R11 isr untouched", v, 8'h00);

        // R3 / R8 reinit as slave with automatic EOI
        bwrite(1'b0, 8'h11);
        bwrite(1'b1, 8'h40);
        bwrite(1'b1, 8'h02);
        bwrite(1'b1, 8'h02);
        check8("R3 slave map", slave_map, 8'h00);
        check8("R3 slave id", {5'd0, slave_id}, 8'h02);
        bwrite(1'b1, 8'h00);
        set_irq(8'h10);
        check8("R8 int_out irq4", {7'd0, int_out}, 8'h01);
        do_ack(8'h44);
        bwrite(1'b0, 8'h0B);
        bread(1'b0, v); check8("R8 isr stays clear", v, 8'h00);
        set_irq(8'h50);
        check8("R8 next granted", {7'd0, int_out}, 8'h01);
        do_ack(8'h46);

        repeat (4) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 missing vectors actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule